// File: doc/BRIEF.md
# Serial Port Byte FIFO Pair with Fill-Level Interrupts

This block holds the receive and transmit byte queues of a serial port. The serial shifter pushes received bytes into the receive queue and the CPU pops them. The CPU pushes bytes into the transmit queue and the shifter pops them. Each queue raises a one-cycle interrupt pulse when its fill level meets a programmed threshold. The threshold is set per direction by a 2-bit level field in a control byte.

A duplex-mode input selects the queue capacity. In half duplex each queue holds four bytes. In full duplex each queue holds two, and only the low bit of each level field is used. An interrupt-select bit in each control byte makes the interrupt fire again on every read made while the fill is at or above the threshold. A self-clearing clear bit empties the queue.

Control byte layout, the same for both directions: bit 7 is the clear bit (write only, reads 0), bit 6 is the interrupt select, bits 1:0 are the level field, and bits 5:2 read 0. `reg_sel_i` = 0 addresses the receive control byte and 1 addresses the transmit control byte.

Top module: `sio_fifo_pair`

## Requirements
- R1: In half duplex the receive threshold is 4 bytes for level 00, 1 for 01, 2 for 10 and 3 for 11. The receive interrupt fires when a push raises the count to the threshold.
- R2: In half duplex the transmit threshold is 0 bytes (empty) for level 00, 1 for 01, 2 for 10 and 3 for 11. The transmit interrupt fires when a pop lowers the count to the threshold.
- R3: With `full_duplex_i` = 1, each queue holds at most 2 bytes and bit 1 of each level field is ignored. Receive uses 2 for low bit 0 and 1 for low bit 1. Transmit uses 0 for low bit 0 and 1 for low bit 1.
- R4: Writing a control byte with bit 7 set empties that queue in the same clock edge. It raises no interrupt, and bit 7 always reads back as 0.
- R5: With the interrupt select (bit 6) at 1, every accepted pop made while the count before the pop is at or above the threshold raises that direction's interrupt.
- R6: After reset both control bytes read 0, both counts are 0 and both interrupts are low.
- R7: A push into a full queue is dropped. A pop from an empty queue changes nothing. The head data output reads 0 while the queue is empty.
- R8: Bytes leave each queue in the order they were accepted.
- R9: Each interrupt is a one-cycle pulse in the cycle after the triggering edge. With the interrupt select at 0, receive pops never raise the receive interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| full_duplex_i | input | 1 | 1 selects full-duplex capacity and level decoding |
| reg_we_i | input | 1 | Control byte write strobe |
| reg_sel_i | input | 1 | 0 = receive control byte, 1 = transmit control byte |
| reg_wdata_i | input | 8 | Control byte write data |
| reg_rdata_o | output | 8 | Selected control byte readback |
| rx_push_i | input | 1 | Shifter pushes a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_pop_i | input | 1 | CPU pops the receive head |
| rx_data_o | output | 8 | Receive head byte, 0 when empty |
| rx_count_o | output | 3 | Receive fill count |
| rx_full_o | output | 1 | Receive queue at capacity |
| rx_irq_o | output | 1 | Receive interrupt pulse |
| tx_push_i | input | 1 | CPU pushes a byte to send |
| tx_data_i | input | 8 | Byte to send |
| tx_pop_i | input | 1 | Shifter pops the transmit head |
| tx_data_o | output | 8 | Transmit head byte, 0 when empty |
| tx_count_o | output | 3 | Transmit fill count |
| tx_full_o | output | 1 | Transmit queue at capacity |
| tx_irq_o | output | 1 | Transmit interrupt pulse |

## Verification
The assertions assume that push and pop strobes last one cycle per byte. They also assume the duplex input changes only while both queues hold no more than two bytes, so a queue is never above its capacity when a strobe arrives. The stimulus drives every strobe for exactly one clock, from the falling edge. It changes the duplex mode only right before a control write that clears the queue. Simultaneous push and pop on one queue are legal for the design but are not used, so each edge moves every count by at most one.

// File: rtl/sio_fifo_pkg.sv
package sio_fifo_pkg;

  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} fifo_dir_e;

  typedef struct packed {
    logic       isel;
    logic [1:0] lvl;
  } fifo_ctrl_t;

  localparam int unsigned CLR_BIT  = 7;
  localparam int unsigned ISEL_BIT = 6;

  // threshold in bytes; depth is the half-duplex capacity
  function automatic int unsigned level_thr(fifo_dir_e dir, logic fdx,
                                            logic [1:0] lvl, int unsigned depth);
    int unsigned t;
    if (dir == DIR_RX) begin
      if (fdx) t = lvl[0] ? 1 : depth / 2;
      else     t = (lvl == 2'b00) ? depth : int'(lvl);
    end else begin
      if (fdx) t = lvl[0] ? 1 : 0;
      else     t = int'(lvl);
    end
    return t;
  endfunction

endpackage

// File: rtl/sio_ctrl_reg.sv
module sio_ctrl_reg
  import sio_fifo_pkg::*;
#(
  parameter int unsigned RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] wdata_i,
  output fifo_ctrl_t    ctrl_o,
  output logic          flush_o,
  output logic [RW-1:0] rdata_o
);

  fifo_ctrl_t ctrl_q;
  logic       unused_bits;

  assign unused_bits = ^wdata_i[ISEL_BIT-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i) begin
      ctrl_q.isel <= wdata_i[ISEL_BIT];
      ctrl_q.lvl  <= wdata_i[1:0];
    end
  end

  // clear is self-clearing: a strobe, never stored
  assign flush_o = we_i && wdata_i[CLR_BIT];
  assign ctrl_o  = ctrl_q;

  always_comb begin
    rdata_o           = '0;
    rdata_o[ISEL_BIT] = ctrl_q.isel;
    rdata_o[1:0]      = ctrl_q.lvl;
  end

endmodule

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned HALF  = DEPTH / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             full_duplex_i,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [DW-1:0]    data_i,
  input  logic             pop_i,
  output logic [DW-1:0]    data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             push_acc_o,
  output logic             pop_acc_o
);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q, cap;

  assign cap        = full_duplex_i ? CNT_W'(HALF) : CNT_W'(DEPTH);
  assign full_o     = cnt_q >= cap;
  assign push_acc_o = push_i && !flush_i && !full_o;
  assign pop_acc_o  = pop_i && !flush_i && (cnt_q != '0);
  assign data_o     = (cnt_q != '0) ? mem_q[rd_q] : '0;
  assign count_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_acc_o) wr_q <= wr_q + 1'b1;
      if (pop_acc_o)  rd_q <= rd_q + 1'b1;
      case ({push_acc_o, pop_acc_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_acc_o) begin
      mem_q[wr_q] <= data_i;
    end
  end

  AST_DROP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !flush_i && cnt_q >= cap) |=> $stable(cnt_q)); // R7
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !flush_i && cnt_q == '0) |=> (cnt_q == '0)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R7

endmodule

// File: rtl/sio_level_irq.sv
module sio_level_irq
  import sio_fifo_pkg::*;
#(
  parameter fifo_dir_e   DIR   = DIR_RX,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             full_duplex_i,
  input  fifo_ctrl_t       ctrl_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             push_acc_i,
  input  logic             pop_acc_i,
  input  logic             flush_i,
  output logic             irq_o
);

  int unsigned thr, cnt_now, cnt_nxt;
  logic        reach, reread, fire, irq_q;

  always_comb begin
    thr     = level_thr(DIR, full_duplex_i, ctrl_i.lvl, DEPTH);
    cnt_now = int'(count_i);
    cnt_nxt = cnt_now + int'(push_acc_i) - int'(pop_acc_i);
    // rx arms on the rising edge of fill, tx on the falling edge
    if (DIR == DIR_RX) reach = push_acc_i && !pop_acc_i && (cnt_nxt == thr);
    else               reach = pop_acc_i && !push_acc_i && (cnt_nxt == thr);
    reread = ctrl_i.isel && pop_acc_i && (cnt_now >= thr);
    fire   = !flush_i && (reach || reread);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= fire;
  end

  assign irq_o = irq_q;

  AST_IRQ_NOT_ON_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !irq_o); // R4
  AST_IRQ_NEEDS_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(push_acc_i || pop_acc_i)); // R9
  AST_RX_POP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DIR == DIR_RX && !ctrl_i.isel && pop_acc_i && !push_acc_i) |=> !irq_o); // R9
  AST_TX_PUSH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DIR == DIR_TX && push_acc_i && !pop_acc_i) |=> !irq_o); // R2

endmodule

// File: rtl/sio_fifo_pair.sv
module sio_fifo_pair
  import sio_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned NDIR  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             full_duplex_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic             rx_push_i,
  input  logic [DW-1:0]    rx_data_i,
  input  logic             rx_pop_i,
  output logic [DW-1:0]    rx_data_o,
  output logic [CNT_W-1:0] rx_count_o,
  output logic             rx_full_o,
  output logic             rx_irq_o,
  input  logic             tx_push_i,
  input  logic [DW-1:0]    tx_data_i,
  input  logic             tx_pop_i,
  output logic [DW-1:0]    tx_data_o,
  output logic [CNT_W-1:0] tx_count_o,
  output logic             tx_full_o,
  output logic             tx_irq_o
);

  logic             push   [NDIR];
  logic             pop    [NDIR];
  logic [DW-1:0]    din    [NDIR];
  logic [DW-1:0]    dout   [NDIR];
  logic [CNT_W-1:0] cnt    [NDIR];
  logic             full   [NDIR];
  logic             irq    [NDIR];
  logic             pacc   [NDIR];
  logic             oacc   [NDIR];
  logic             flush  [NDIR];
  fifo_ctrl_t       ctrl   [NDIR];
  logic [7:0]       rdata  [NDIR];

  assign push[0] = rx_push_i;  assign pop[0] = rx_pop_i;  assign din[0] = rx_data_i;
  assign push[1] = tx_push_i;  assign pop[1] = tx_pop_i;  assign din[1] = tx_data_i;

  assign rx_data_o = dout[0];  assign rx_count_o = cnt[0];
  assign rx_full_o = full[0];  assign rx_irq_o   = irq[0];
  assign tx_data_o = dout[1];  assign tx_count_o = cnt[1];
  assign tx_full_o = full[1];  assign tx_irq_o   = irq[1];

  assign reg_rdata_o = reg_sel_i ? rdata[1] : rdata[0];

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    localparam fifo_dir_e DIR_D = (d == 0) ? DIR_RX : DIR_TX;

    sio_ctrl_reg #(.RW(8)) u_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (reg_we_i && (reg_sel_i == DIR_D)),
      .wdata_i (reg_wdata_i),
      .ctrl_o  (ctrl[d]),
      .flush_o (flush[d]),
      .rdata_o (rdata[d])
    );

    sio_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .full_duplex_i (full_duplex_i),
      .flush_i       (flush[d]),
      .push_i        (push[d]),
      .data_i        (din[d]),
      .pop_i         (pop[d]),
      .data_o        (dout[d]),
      .count_o       (cnt[d]),
      .full_o        (full[d]),
      .push_acc_o    (pacc[d]),
      .pop_acc_o     (oacc[d])
    );

    sio_level_irq #(.DIR(DIR_D), .DEPTH(DEPTH)) u_irq (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .full_duplex_i (full_duplex_i),
      .ctrl_i        (ctrl[d]),
      .count_i       (cnt[d]),
      .push_acc_i    (pacc[d]),
      .pop_acc_i     (oacc[d]),
      .flush_i       (flush[d]),
      .irq_o         (irq[d])
    );
  end

  AST_CLR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[CLR_BIT]); // R4
  AST_FDX_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_duplex_i && rx_count_o >= CNT_W'(DEPTH / 2) && rx_push_i && !rx_pop_i)
      |=> $stable(rx_count_o)); // R3

endmodule

// File: tb/tb_sio_fifo_pair.sv
`timescale 1ns/1ps
module tb_sio_fifo_pair;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       full_duplex_i = 1'b0;
  logic       reg_we_i = 1'b0, reg_sel_i = 1'b0;
  logic [7:0] reg_wdata_i = '0, reg_rdata_o;
  logic       rx_push_i = 1'b0, rx_pop_i = 1'b0, rx_full_o, rx_irq_o;
  logic [7:0] rx_data_i = '0, rx_data_o;
  logic [2:0] rx_count_o;
  logic       tx_push_i = 1'b0, tx_pop_i = 1'b0, tx_full_o, tx_irq_o;
  logic [7:0] tx_data_i = '0, tx_data_o;
  logic [2:0] tx_count_o;

  int checks = 0, fails = 0;

  always #10 clk_i = ~clk_i;

  sio_fifo_pair dut (.*);

  // {full_duplex, dir(0 rx / 1 tx), level[1:0], expected threshold[3:0]}
  localparam logic [7:0] VEC [16] = '{
    8'b0_0_00_0100, 8'b0_0_01_0001, 8'b0_0_10_0010, 8'b0_0_11_0011,  // R1
    8'b0_1_00_0000, 8'b0_1_01_0001, 8'b0_1_10_0010, 8'b0_1_11_0011,  // R2
    8'b1_0_00_0010, 8'b1_0_01_0001, 8'b1_0_10_0010, 8'b1_0_11_0001,  // R3
    8'b1_1_00_0000, 8'b1_1_01_0001, 8'b1_1_10_0000, 8'b1_1_11_0001   // R3
  };

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic sel, logic [7:0] d);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rx_push(logic [7:0] d);
    rx_push_i = 1'b1; rx_data_i = d; @(negedge clk_i); rx_push_i = 1'b0;
  endtask
  task automatic rx_pop();
    rx_pop_i = 1'b1; @(negedge clk_i); rx_pop_i = 1'b0;
  endtask
  task automatic tx_push(logic [7:0] d);
    tx_push_i = 1'b1; tx_data_i = d; @(negedge clk_i); tx_push_i = 1'b0;
  endtask
  task automatic tx_pop();
    tx_pop_i = 1'b1; @(negedge clk_i); tx_pop_i = 1'b0;
  endtask

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog R6: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R6 reset state
    chk("R6", "rx count", rx_count_o, 0);
    chk("R6", "tx count", tx_count_o, 0);
    chk("R6", "irqs", {rx_irq_o, tx_irq_o}, 0);
    reg_sel_i = 1'b0; #1 chk("R6", "rx ctrl", reg_rdata_o, 0);
    reg_sel_i = 1'b1; #1 chk("R6", "tx ctrl", reg_rdata_o, 0);
    @(negedge clk_i);

    // threshold table
    for (int v = 0; v < 16; v++) begin
      automatic logic       fd  = VEC[v][7];
      automatic logic       dir = VEC[v][6];
      automatic logic [1:0] lvl = VEC[v][5:4];
      automatic int         exp = int'(VEC[v][3:0]);
      automatic int         cap = fd ? 2 : 4;
      automatic int         hit = 15;
      automatic string      req = fd ? "R3" : (dir ? "R2" : "R1");
      full_duplex_i = fd;
      wr_ctrl(dir, {1'b1, 5'b0, lvl});
      if (!dir) begin
        for (int k = 0; k < cap; k++) begin
          rx_push(8'(k + 1));
          if (rx_irq_o && hit == 15) hit = rx_count_o;
        end
      end else begin
        for (int k = 0; k < cap; k++) tx_push(8'(k + 1));
        for (int k = 0; k < cap; k++) begin
          tx_pop();
          if (tx_irq_o && hit == 15) hit = tx_count_o;
        end
      end
      chk(req, $sformatf("threshold vec %0d", v), hit, exp);
    end

    // R8 order, half duplex
    full_duplex_i = 1'b0;
    wr_ctrl(1'b0, 8'h80);
    rx_push(8'h11); rx_push(8'h22); rx_push(8'h33);
    chk("R8", "head 1", rx_data_o, 8'h11); rx_pop();
    chk("R8", "head 2", rx_data_o, 8'h22); rx_pop();
    chk("R8", "head 3", rx_data_o, 8'h33); rx_pop();

    // R7 overfill and empty pop
    for (int k = 1; k <= 5; k++) rx_push(8'(k));
    chk("R7", "rx count full", rx_count_o, 4);
    chk("R7", "rx full flag", rx_full_o, 1);
    for (int k = 1; k <= 4; k++) begin
      chk("R7", "kept byte", rx_data_o, k); rx_pop();
    end
    chk("R7", "empty head", rx_data_o, 0);
    rx_pop();
    chk("R7", "empty pop count", rx_count_o, 0);
    chk("R7", "empty pop irq", rx_irq_o, 0);

    // R3 full-duplex capacity on tx
    full_duplex_i = 1'b1;
    wr_ctrl(1'b1, 8'h80);
    tx_push(8'hA1); tx_push(8'hA2); tx_push(8'hA3);
    chk("R3", "tx count cap", tx_count_o, 2);
    chk("R3", "tx full flag", tx_full_o, 1);

    // R4 flush with tx level empty: no irq
    wr_ctrl(1'b1, 8'h80);
    chk("R4", "flush count", tx_count_o, 0);
    chk("R4", "flush irq", tx_irq_o, 0);
    @(negedge clk_i);
    chk("R4", "flush irq later", tx_irq_o, 0);

    // R4 clear bit reads 0
    full_duplex_i = 1'b0;
    wr_ctrl(1'b0, 8'hC3);
    reg_sel_i = 1'b0; #1 chk("R4", "rx ctrl readback", reg_rdata_o, 8'h43);
    @(negedge clk_i);

    // R5 rx reread, level 1
    wr_ctrl(1'b0, 8'hC1);
    rx_push(8'h01); chk("R9", "rx irq on reach", rx_irq_o, 1);
    @(negedge clk_i); chk("R9", "rx irq one cycle", rx_irq_o, 0);
    rx_push(8'h02); chk("R5", "rx push above", rx_irq_o, 0);
    rx_push(8'h03); chk("R5", "rx push above 2", rx_irq_o, 0);
    rx_pop(); chk("R5", "rx pop at 3", rx_irq_o, 1);
    rx_pop(); chk("R5", "rx pop at 2", rx_irq_o, 1);
    rx_pop(); chk("R5", "rx pop at 1", rx_irq_o, 1);
    rx_pop(); chk("R5", "rx pop empty", rx_irq_o, 0);

    // R9 rx select 0: pops silent
    wr_ctrl(1'b0, 8'h81);
    rx_push(8'h01); rx_push(8'h02); rx_push(8'h03);
    for (int k = 0; k < 3; k++) begin
      rx_pop(); chk("R9", "rx pop quiet", rx_irq_o, 0);
    end

    // R5 tx reread, level 2
    wr_ctrl(1'b1, 8'hC2);
    for (int k = 0; k < 4; k++) begin
      tx_push(8'(k)); chk("R2", "tx push quiet", tx_irq_o, 0);
    end
    tx_pop(); chk("R5", "tx pop at 4", tx_irq_o, 1);
    tx_pop(); chk("R5", "tx pop at 3", tx_irq_o, 1);
    tx_pop(); chk("R5", "tx pop at 2", tx_irq_o, 1);
    tx_pop(); chk("R5", "tx pop at 1", tx_irq_o, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule